// File: doc/BRIEF.md
# Pattern Bank Address Mapper

This block turns a 13-bit pattern-table fetch address from a video fetch unit into a 20-bit physical address in character ROM. It holds two groups of bank registers, an eight-entry group that serves sprite fetches and a four-entry group that serves background fetches. A two-bit mode picks the window size that every bank covers: 8 KB, 4 KB, 2 KB or 1 KB. Each bank value is 10 bits wide. The upper two bits of a bank value come from a separate high-bits register, and they are taken at the moment the low byte of that bank is written.

The output address is combinational in the fetch address, the horizontal position and the register state. Registers are written through a narrow select/data port. In the normal case the group used for the translation is the one whose register was written last. When the large-sprite flag is set, the horizontal fetch position decides the group instead.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset the mode is 0, every bank value and the high bits are 0, the large-sprite flag is clear and the sprite group is active, so rom_addr equals pat_addr zero-extended.
- R2: A write with wr_en high stores data on the rising clock edge, according to the select code. Codes 0 to 7 write sprite bank 0 to 7 and codes 8 to 11 write background bank 0 to 3. Code 12 stores the mode from data bits 1:0, code 13 stores the high bits from data bits 1:0, and code 14 stores the large-sprite flag from data bit 5. Code 15 changes nothing.
- R3: A bank write stores {high bits held at that moment, data byte}. Changing the high bits later leaves stored banks unchanged.
- R4: Writing any sprite bank makes the sprite group active, and writing any background bank makes the background group active.
- R5: Sprite group, mode 0: bank 7 covers an 8 KB window. Mode 1: address bit 12 picks bank 3 or bank 7, each covering 4 KB.
- R6: Sprite group, mode 2: address bits 12:11 pick bank 1, 3, 5 or 7, each covering 2 KB. Mode 3: address bits 12:10 pick bank 0 to 7, each covering 1 KB.
- R7: Background group: address bit 12 is dropped first. Mode 0 gives background bank 3 times 8 KB plus the 12-bit offset. Mode 1 gives bank 3 covering 4 KB. Mode 2 uses bit 11 to pick bank 1 or 3 at 2 KB. Mode 3 uses bits 11:10 to pick bank 0 to 3 at 1 KB.
- R8: With the large-sprite flag set, a fetch at hpos below 256 or at 320 and above uses the background group, and any other fetch uses the sprite group, whichever group was written last.
- R9: rom_addr is the bank value shifted left by the window size in address bits, OR the in-window offset, truncated to 20 bits.
- R10: With wr_en low, no register changes, whatever the select code and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 8 | Register write data |
| pat_addr | input | 13 | Pattern-table fetch address |
| hpos | input | 9 | Horizontal fetch position |
| rom_addr | output | 20 | Physical character-ROM address |

## Verification
The assertions assume that wr_sel, wr_data, wr_en, pat_addr and hpos are stable around each rising edge. They also assume that hpos is a plain 9-bit count, with no meaning attached to values above the last fetch slot. The bench changes every input only on the falling edge and sweeps hpos across 255, 256, 319 and 320, so the check of which group serves a fetch sees each side of both boundaries. The select codes the bench uses are the fifteen listed codes plus code 15, which is applied on purpose to show that it has no effect.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  typedef enum logic [1:0] {
    WIN_8K = 2'd0,
    WIN_4K = 2'd1,
    WIN_2K = 2'd2,
    WIN_1K = 2'd3
  } win_mode_e;

  localparam int SEL_W        = 4;
  localparam int SEL_SPR_BASE = 0;
  localparam int SEL_BG_BASE  = 8;
  localparam int SEL_MODE     = 12;
  localparam int SEL_HIBITS   = 13;
  localparam int SEL_VCTRL    = 14;
  localparam int BIG_SPR_BIT  = 5;

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_map_pkg::*;
#(
  parameter int NSPR   = 8,
  parameter int NBG    = 4,
  parameter int BANK_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [DATA_W-1:0]                 wr_data,
  output win_mode_e                         mode_o,
  output logic [NSPR-1:0][BANK_W-1:0]       spr_banks_o,
  output logic [NBG-1:0][BANK_W-1:0]        bg_banks_o,
  output logic                              bg_active_o,
  output logic                              big_spr_o
);

  localparam int HI_W = BANK_W - DATA_W;

  win_mode_e                   mode_q, mode_d;
  logic [HI_W-1:0]             hi_q, hi_d;
  logic [NSPR-1:0][BANK_W-1:0] spr_q, spr_d;
  logic [NBG-1:0][BANK_W-1:0]  bg_q, bg_d;
  logic                        act_q, act_d;
  logic                        big_q, big_d;

  // next-state
  always_comb begin
    mode_d = mode_q;
    hi_d   = hi_q;
    spr_d  = spr_q;
    bg_d   = bg_q;
    act_d  = act_q;
    big_d  = big_q;
    for (int i = 0; i < NSPR; i++) begin
      if (wr_sel == SEL_W'(SEL_SPR_BASE + i)) begin
        spr_d[i] = {hi_q, wr_data};
        act_d    = 1'b0;
      end
    end
    for (int j = 0; j < NBG; j++) begin
      if (wr_sel == SEL_W'(SEL_BG_BASE + j)) begin
        bg_d[j] = {hi_q, wr_data};
        act_d   = 1'b1;
      end
    end
    if (wr_sel == SEL_W'(SEL_MODE))   mode_d = win_mode_e'(wr_data[1:0]);
    if (wr_sel == SEL_W'(SEL_HIBITS)) hi_d   = wr_data[HI_W-1:0];
    if (wr_sel == SEL_W'(SEL_VCTRL))  big_d  = wr_data[BIG_SPR_BIT];
  end

  // registers with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WIN_8K;
      hi_q   <= '0;
      spr_q  <= '0;
      bg_q   <= '0;
      act_q  <= 1'b0;
      big_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      hi_q   <= hi_d;
      spr_q  <= spr_d;
      bg_q   <= bg_d;
      act_q  <= act_d;
      big_q  <= big_d;
    end
  end

  assign mode_o      = mode_q;
  assign spr_banks_o = spr_q;
  assign bg_banks_o  = bg_q;
  assign bg_active_o = act_q;
  assign big_spr_o   = big_q;

  assert_spr_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < SEL_W'(SEL_BG_BASE)) |=> !bg_active_o);

  assert_bg_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= SEL_W'(SEL_BG_BASE) && wr_sel < SEL_W'(SEL_BG_BASE + NBG))
      |=> bg_active_o);

  assert_hi_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(SEL_SPR_BASE))
      |=> spr_banks_o[0] == {$past(hi_q), $past(wr_data)});

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_o) && $stable(spr_banks_o) && $stable(bg_banks_o)
                && $stable(bg_active_o) && $stable(big_spr_o)));

endmodule

// File: rtl/chr_window_calc.sv
module chr_window_calc
  import chr_map_pkg::*;
#(
  parameter int NBANK       = 8,
  parameter int REGION_BITS = 13,
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 10,
  parameter int OUT_W       = 20
) (
  input  win_mode_e                    mode,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NBANK-1:0][BANK_W-1:0] banks,
  output logic [OUT_W-1:0]             phys
);

  localparam int LB   = $clog2(NBANK);
  localparam int SKIP = ADDR_W - REGION_BITS;
  localparam int WW   = OUT_W + ADDR_W;
  localparam logic [ADDR_W-1:0] RMASK = ADDR_W'((1 << REGION_BITS) - 1);

  logic [ADDR_W-1:0] am, seg, offm;
  logic [LB-1:0]     idx;
  logic [WW-1:0]     wide;
  int                sh, k, idx_i;

  always_comb begin
    am    = addr & RMASK;
    sh    = ADDR_W - int'(mode);
    k     = (int'(mode) > SKIP) ? int'(mode) - SKIP : 0;
    seg   = am >> (REGION_BITS - k);
    idx_i = (int'(seg) << (LB - k)) | ((1 << (LB - k)) - 1);
    idx   = idx_i[LB-1:0];
    offm  = (ADDR_W'(1) << sh) - ADDR_W'(1);
    wide  = ({{(WW-BANK_W){1'b0}}, banks[idx]} << sh)
          | {{OUT_W{1'b0}}, (am & offm)};
    phys  = wide[OUT_W-1:0];
  end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 10,
  parameter int DATA_W = 8,
  parameter int OUT_W  = 20,
  parameter int HPOS_W = 9,
  parameter int NSPR   = 8,
  parameter int NBG    = 4,
  parameter int BG_LO  = 256,
  parameter int BG_HI  = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [12:0]       pat_addr,
  input  logic [8:0]        hpos,
  output logic [19:0]       rom_addr
);

  win_mode_e                   mode;
  logic [NSPR-1:0][BANK_W-1:0] spr_banks;
  logic [NBG-1:0][BANK_W-1:0]  bg_banks;
  logic                        bg_active, big_spr;
  logic [OUT_W-1:0]            spr_phys, bg_phys;
  logic                        bg_window, use_bg;

  chr_bank_regs #(
    .NSPR(NSPR), .NBG(NBG), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode_o(mode), .spr_banks_o(spr_banks),
    .bg_banks_o(bg_banks), .bg_active_o(bg_active), .big_spr_o(big_spr)
  );

  chr_window_calc #(
    .NBANK(NSPR), .REGION_BITS(ADDR_W), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .OUT_W(OUT_W)
  ) spr_calc_i (
    .mode(mode), .addr(pat_addr), .banks(spr_banks), .phys(spr_phys)
  );

  chr_window_calc #(
    .NBANK(NBG), .REGION_BITS(ADDR_W-1), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .OUT_W(OUT_W)
  ) bg_calc_i (
    .mode(mode), .addr(pat_addr), .banks(bg_banks), .phys(bg_phys)
  );

  always_comb begin
    bg_window = (hpos < HPOS_W'(BG_LO)) || (hpos >= HPOS_W'(BG_HI));
    use_bg    = big_spr ? bg_window : bg_active;
    rom_addr  = use_bg ? bg_phys : spr_phys;
  end

  assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[9:0] == pat_addr[9:0]);

  assert_big_bg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (big_spr && (hpos < 9'd256 || hpos >= 9'd320)) |-> rom_addr == bg_phys);

  assert_big_spr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (big_spr && hpos >= 9'd256 && hpos < 9'd320) |-> rom_addr == spr_phys);

endmodule

// File: tb/chr_bank_mapper_tb.sv
`timescale 1ns/1ps
module chr_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [12:0] pat_addr;
  logic [8:0]  hpos;
  logic [19:0] rom_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int spr_m [8];
  int bg_m  [4];
  int hi_m;

  always #4 clk = ~clk;

  chr_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pat_addr(pat_addr), .hpos(hpos), .rom_addr(rom_addr)
  );

  // vector: {mode[1:0], bg_last, big, hpos[8:0], addr[12:0]}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 9'd0,   13'h1234},
    {2'd1, 1'b0, 1'b0, 9'd0,   13'h0ABC},
    {2'd1, 1'b0, 1'b0, 9'd0,   13'h1ABC},
    {2'd2, 1'b0, 1'b0, 9'd0,   13'h0123},
    {2'd2, 1'b0, 1'b0, 9'd0,   13'h0923},
    {2'd2, 1'b0, 1'b0, 9'd0,   13'h1123},
    {2'd2, 1'b0, 1'b0, 9'd0,   13'h1923},
    {2'd3, 1'b0, 1'b0, 9'd0,   13'h0011},
    {2'd3, 1'b0, 1'b0, 9'd0,   13'h0411},
    {2'd3, 1'b0, 1'b0, 9'd0,   13'h0C11},
    {2'd3, 1'b0, 1'b0, 9'd0,   13'h1C11},
    {2'd0, 1'b1, 1'b0, 9'd0,   13'h1FFF},
    {2'd1, 1'b1, 1'b0, 9'd0,   13'h1ABC},
    {2'd2, 1'b1, 1'b0, 9'd0,   13'h0123},
    {2'd2, 1'b1, 1'b0, 9'd0,   13'h0923},
    {2'd3, 1'b1, 1'b0, 9'd0,   13'h0C55},
    {2'd3, 1'b1, 1'b0, 9'd0,   13'h1455},
    {2'd3, 1'b0, 1'b1, 9'd255, 13'h0400},
    {2'd3, 1'b0, 1'b1, 9'd256, 13'h0400},
    {2'd3, 1'b0, 1'b1, 9'd319, 13'h0400},
    {2'd3, 1'b0, 1'b1, 9'd320, 13'h0400},
    {2'd3, 1'b1, 1'b1, 9'd300, 13'h0800},
    {2'd2, 1'b1, 1'b1, 9'd100, 13'h1923},
    {2'd1, 1'b0, 1'b1, 9'd340, 13'h1001}
  };

  function automatic int model(input int mode, input bit bg, input int a);
    int r, b;
    r = 0;
    if (!bg) begin
      case (mode)
        0: r = spr_m[7] * 8192 + (a % 8192);
        1: r = spr_m[(a / 4096) % 2 == 1 ? 7 : 3] * 4096 + (a % 4096);
        2: r = spr_m[((a / 2048) % 4) * 2 + 1] * 2048 + (a % 2048);
        default: r = spr_m[(a / 1024) % 8] * 1024 + (a % 1024);
      endcase
    end else begin
      b = a % 4096;
      case (mode)
        0: r = bg_m[3] * 8192 + b;
        1: r = bg_m[3] * 4096 + b;
        2: r = bg_m[(b / 2048) * 2 + 1] * 2048 + (b % 2048);
        default: r = bg_m[b / 1024] * 1024 + (b % 1024);
      endcase
    end
    return r % (1 << 20);
  endfunction

  task automatic check(input string req, input int exp);
    n_checks++;
    if (rom_addr !== 20'(exp)) begin
      n_fail++;
      $display("FAIL %s: rom_addr got %h expected %h", req, rom_addr, 20'(exp));
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_bank(input int sel, input int val);
    wr(13, val / 256);
    wr(sel, val % 256);
    hi_m = val / 256;
    if (sel < 8) spr_m[sel] = val; else bg_m[sel-8] = val;
  endtask

  task automatic probe(input int a, input int h);
    @(negedge clk);
    pat_addr = 13'(a); hpos = 9'(h);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (spr_m[i]) spr_m[i] = 0;
    foreach (bg_m[i]) bg_m[i] = 0;
    hi_m = 0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v, m, h, a, exp;
    bit bgl, big, use_bg;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    pat_addr = '0; hpos = '0;
    do_reset();

    // R1: reset state maps straight through
    probe(13'h1ABC, 0);
    check("R1", 32'h01ABC);

    // load distinct banks with varied high bits (R2, R3)
    for (int i = 0; i < 8; i++) wr_bank(i, (i % 4) * 256 + 16 + i * 17);
    for (int j = 0; j < 4; j++) wr_bank(8 + j, (3 - j) * 256 + 160 + j);

    // table-driven translation sweep (R5, R6, R7, R8, R4, R9)
    for (int t = 0; t < NV; t++) begin
      v   = int'(VEC[t]);
      m   = int'(VEC[t][25:24]);
      bgl = VEC[t][23];
      big = VEC[t][22];
      h   = int'(VEC[t][21:13]);
      a   = int'(VEC[t][12:0]);
      wr(12, m);
      wr(14, big ? 32'h20 : 32'h00);
      if (bgl) wr_bank(8, bg_m[0]); else wr_bank(0, spr_m[0]);
      use_bg = big ? (h < 256 || h >= 320) : bgl;
      exp = model(m, use_bg, a);
      probe(a, h);
      if (big)          check("R8", exp);
      else if (use_bg)  check("R7_R4", exp);
      else if (m < 2)   check("R5_R4", exp);
      else              check("R6_R4", exp);
    end

    // R3: later high-bit change leaves stored bank alone
    wr(14, 0);
    wr(12, 3);
    wr_bank(5, 2 * 256 + 8'h33);
    wr(13, 1);
    probe(13'h1400, 0);
    check("R3", 32'h233 << 10);

    // R9: 8 KB window with full bank truncates to 20 bits
    wr(12, 0);
    wr_bank(7, 32'h3FF);
    probe(13'h0005, 0);
    check("R9", 32'hFE005);

    // R10: strobe low, mode select present, nothing changes
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 4'd12; wr_data = 8'h03;
    @(negedge clk);
    wr_sel = 4'd7; wr_data = 8'h00;
    @(negedge clk);
    probe(13'h0005, 0);
    check("R10", 32'hFE005);

    // R2: code 15 is inert
    wr(15, 32'hFF);
    probe(13'h0005, 0);
    check("R2", 32'hFE005);

    // R2: code 14 with bit 5 clear keeps set choice from last write
    wr(12, 3);
    wr_bank(9, 32'h155);
    wr(14, 32'hDF);
    probe(13'h0400, 290);
    check("R2_R4", model(3, 1'b1, 32'h0400));

    // R1: reset in mid-run restores straight mapping
    do_reset();
    probe(13'h0777, 0);
    check("R1", 32'h00777);

    done = 1'b1;
    if (v < 0) $display("unused");
    finish_run();
  end

endmodule